// File: doc/BRIEF.md
# Dual-Port Semaphore Latch Bank

This block gives two independent ports, left and right, a set of hardware mutual-exclusion flags that guard a resource both sides share. Each port has its own address, semaphore select, chip enable, read/write and data lines. To claim a flag, a port writes a request to it. It then reads the flag back to learn whether it holds ownership. Writing the opposite value withdraws a pending request or gives up ownership.

A request made while the other side holds the flag stays pending. It is granted one cycle after the holder lets go, provided the requester has not withdrawn it. If both ports claim the same free flag in one cycle, the tie always goes to the left port. Each port also reports an idle indication for power-down, taken only from its own select lines.

The block runs on a single clock with an active-low asynchronous reset. Readback is combinational from the ownership state, so a read in the cycle after a write already reflects that write.

Top module: `dp_sema_bank`

## Requirements
- R1: The bank holds eight independent flags. The three least significant address bits of the accessing port pick the flag. All higher address bits are ignored, and an access to one flag leaves every other flag unchanged.
- R2: A port reaches the flags only while its active-low semaphore select is low. While that select is high, writes change nothing and the port's read data is all ones.
- R3: An access is ignored when the port's active-low chip enable is low, even if its semaphore select is also low. In that case writes change nothing and the read data is all ones.
- R4: Writing data bit 0 = 0 to a free flag grants it to the writing port. A read in the next cycle returns data bit 0 = 0, and data bits 7..1 always read as 1.
- R5: A read returns data bit 0 = 1 when the reading port does not own the flag, whether the flag is free or held by the other side.
- R6: Writing data bit 0 = 1 releases the writer's ownership, or withdraws its pending request. The port's next read returns bit 0 = 1.
- R7: A request made while the other side owns the flag stays pending. After the owner's release write in cycle t, the requester's read in cycle t+1 still returns 1. From cycle t+2 onward, its read returns 0.
- R8: A pending request that is withdrawn in the cycle after the owner's release is never granted, and the flag stays free.
- R9: When both ports write a request to the same free flag in the same cycle, the left port is granted. The right port's request stays pending.
- R10: Each port's idle output is high exactly when both its chip enable and its semaphore select are high. It does not depend on the other port.
- R11: Reset, asserted at any time, clears every request and every ownership, so that all flags are free.
- R12: A flag is never owned by both sides. An owner keeps the flag until it writes a release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| l_addr_i | input | 10 | Left address, low 3 bits select the flag |
| l_sel_ni | input | 1 | Left semaphore select, active low |
| l_ce_ni | input | 1 | Left memory chip enable, active low |
| l_we_i | input | 1 | Left write (1) or read (0) |
| l_wdata_i | input | 8 | Left write data, bit 0 used |
| l_rdata_o | output | 8 | Left read data |
| l_idle_o | output | 1 | Left idle / power-down indication |
| r_addr_i | input | 10 | Right address, low 3 bits select the flag |
| r_sel_ni | input | 1 | Right semaphore select, active low |
| r_ce_ni | input | 1 | Right memory chip enable, active low |
| r_we_i | input | 1 | Right write (1) or read (0) |
| r_wdata_i | input | 8 | Right write data, bit 0 used |
| r_rdata_o | output | 8 | Right read data |
| r_idle_o | output | 1 | Right idle / power-down indication |

## Verification
Some properties are checked on every clock cycle. An owner always has a live request behind it and keeps the flag until it releases. A tie on a free flag always goes to the left port, and a standing pending request is granted once the flag is free. A port that is disabled or idle produces no write strobes, and its read data stays all ones. Other behaviours can only be shown by the bench's scenarios, because they depend on the exact cycle-by-cycle handoff seen at the ports. These are the one-cycle gap before a pending request is granted, withdrawal racing a release, isolation between the eight flags under varying upper address bits, and reset in the middle of a run.

// File: rtl/sema_pkg.sv
package sema_pkg;
  typedef enum logic [1:0] {
    OWN_NONE  = 2'b00,
    OWN_LEFT  = 2'b01,
    OWN_RIGHT = 2'b10
  } own_e;
endpackage

// File: rtl/sema_port_dec.sv
module sema_port_dec #(
  parameter int NUM_FLAGS = 8,
  parameter int ADDR_W    = 10,
  parameter int DATA_W    = 8,
  localparam int IDX_W    = $clog2(NUM_FLAGS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic                 sel_ni,
  input  logic                 ce_ni,
  input  logic                 we_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic [NUM_FLAGS-1:0] req_set_o,
  output logic [NUM_FLAGS-1:0] req_clr_o,
  output logic                 rd_en_o,
  output logic [IDX_W-1:0]     idx_o,
  output logic                 idle_o
);
  logic access;
  logic unused_bits;

  // semaphore path only when select low and memory enable high
  assign access      = !sel_ni && ce_ni;
  assign idx_o       = addr_i[IDX_W-1:0];
  assign rd_en_o     = access && !we_i;
  assign idle_o      = sel_ni && ce_ni;
  assign unused_bits = ^{addr_i[ADDR_W-1:IDX_W], wdata_i[DATA_W-1:1]};

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_strobe
    logic hit;
    assign hit          = access && we_i && (idx_o == IDX_W'(g));
    assign req_set_o[g] = hit && !wdata_i[0];
    assign req_clr_o[g] = hit &&  wdata_i[0];
  end

  p_idle_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_o |-> (req_set_o == '0 && req_clr_o == '0 && !rd_en_o));
  p_ce_blocks_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ce_ni |-> (req_set_o == '0 && req_clr_o == '0 && !rd_en_o));
  p_one_strobe_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(req_set_o | req_clr_o));
endmodule

// File: rtl/sema_flag.sv
module sema_flag
  import sema_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic l_set_i,
  input  logic l_clr_i,
  input  logic r_set_i,
  input  logic r_clr_i,
  output logic l_own_o,
  output logic r_own_o
);
  logic l_req_q, r_req_q, l_req_d, r_req_d;
  own_e owner_q, owner_d;

  assign l_req_d = (l_req_q || l_set_i) && !l_clr_i;
  assign r_req_d = (r_req_q || r_set_i) && !r_clr_i;

  // release always passes through free; left wins on a free flag
  always_comb begin
    owner_d = owner_q;
    unique case (owner_q)
      OWN_NONE:  if (l_req_d) owner_d = OWN_LEFT;
                 else if (r_req_d) owner_d = OWN_RIGHT;
      OWN_LEFT:  if (!l_req_d) owner_d = OWN_NONE;
      OWN_RIGHT: if (!r_req_d) owner_d = OWN_NONE;
      default:   owner_d = OWN_NONE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      l_req_q <= 1'b0;
      r_req_q <= 1'b0;
      owner_q <= OWN_NONE;
    end else begin
      l_req_q <= l_req_d;
      r_req_q <= r_req_d;
      owner_q <= owner_d;
    end
  end

  assign l_own_o = (owner_q == OWN_LEFT);
  assign r_own_o = (owner_q == OWN_RIGHT);

  p_left_backed_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (owner_q == OWN_LEFT) |-> l_req_q);
  p_right_backed_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (owner_q == OWN_RIGHT) |-> r_req_q);
  p_left_keeps_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (owner_q == OWN_LEFT && !l_clr_i) |=> (owner_q == OWN_LEFT));
  p_right_keeps_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (owner_q == OWN_RIGHT && !r_clr_i) |=> (owner_q == OWN_RIGHT));
  p_tie_left_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (owner_q == OWN_NONE && l_set_i && r_set_i) |=> (owner_q == OWN_LEFT));
  p_release_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (owner_q == OWN_LEFT && l_clr_i) |=> (owner_q == OWN_NONE));
  p_pending_grant_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (owner_q == OWN_NONE && r_req_q && !r_clr_i && !l_req_q && !l_set_i)
      |=> (owner_q == OWN_RIGHT));
endmodule

// File: rtl/sema_rd_mux.sv
module sema_rd_mux #(
  parameter int NUM_FLAGS = 8,
  parameter int DATA_W    = 8,
  localparam int IDX_W    = $clog2(NUM_FLAGS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_FLAGS-1:0] own_i,
  input  logic                 rd_en_i,
  input  logic [IDX_W-1:0]     idx_i,
  output logic [DATA_W-1:0]    rdata_o
);
  // bit 0 low means "you hold it"; all other bits idle high
  always_comb begin
    rdata_o = '1;
    if (rd_en_i) rdata_o[0] = !own_i[idx_i];
  end

  p_upper_ones_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    &rdata_o[DATA_W-1:1]);
  p_no_read_ones_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |-> (&rdata_o));
endmodule

// File: rtl/dp_sema_bank.sv
module dp_sema_bank #(
  parameter int NUM_FLAGS = 8,
  parameter int ADDR_W    = 10,
  parameter int DATA_W    = 8,
  localparam int IDX_W    = $clog2(NUM_FLAGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] l_addr_i,
  input  logic              l_sel_ni,
  input  logic              l_ce_ni,
  input  logic              l_we_i,
  input  logic [DATA_W-1:0] l_wdata_i,
  output logic [DATA_W-1:0] l_rdata_o,
  output logic              l_idle_o,
  input  logic [ADDR_W-1:0] r_addr_i,
  input  logic              r_sel_ni,
  input  logic              r_ce_ni,
  input  logic              r_we_i,
  input  logic [DATA_W-1:0] r_wdata_i,
  output logic [DATA_W-1:0] r_rdata_o,
  output logic              r_idle_o
);
  logic [NUM_FLAGS-1:0] l_set, l_clr, r_set, r_clr, l_own, r_own;
  logic                 l_rd, r_rd;
  logic [IDX_W-1:0]     l_idx, r_idx;

  sema_port_dec #(.NUM_FLAGS(NUM_FLAGS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_l_dec (
    .clk_i, .rst_ni,
    .addr_i(l_addr_i), .sel_ni(l_sel_ni), .ce_ni(l_ce_ni), .we_i(l_we_i),
    .wdata_i(l_wdata_i), .req_set_o(l_set), .req_clr_o(l_clr),
    .rd_en_o(l_rd), .idx_o(l_idx), .idle_o(l_idle_o)
  );

  sema_port_dec #(.NUM_FLAGS(NUM_FLAGS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_r_dec (
    .clk_i, .rst_ni,
    .addr_i(r_addr_i), .sel_ni(r_sel_ni), .ce_ni(r_ce_ni), .we_i(r_we_i),
    .wdata_i(r_wdata_i), .req_set_o(r_set), .req_clr_o(r_clr),
    .rd_en_o(r_rd), .idx_o(r_idx), .idle_o(r_idle_o)
  );

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    sema_flag u_flag (
      .clk_i, .rst_ni,
      .l_set_i(l_set[g]), .l_clr_i(l_clr[g]),
      .r_set_i(r_set[g]), .r_clr_i(r_clr[g]),
      .l_own_o(l_own[g]), .r_own_o(r_own[g])
    );
  end

  sema_rd_mux #(.NUM_FLAGS(NUM_FLAGS), .DATA_W(DATA_W)) u_l_rd (
    .clk_i, .rst_ni, .own_i(l_own), .rd_en_i(l_rd), .idx_i(l_idx), .rdata_o(l_rdata_o)
  );

  sema_rd_mux #(.NUM_FLAGS(NUM_FLAGS), .DATA_W(DATA_W)) u_r_rd (
    .clk_i, .rst_ni, .own_i(r_own), .rd_en_i(r_rd), .idx_i(r_idx), .rdata_o(r_rdata_o)
  );

  p_exclusive_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (l_own & r_own) == '0);
endmodule

// File: tb/tb_dp_sema_bank.sv
module tb_dp_sema_bank;
  localparam int AW = 10;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] l_addr, r_addr;
  logic          l_sel_n, l_ce_n, l_we, r_sel_n, r_ce_n, r_we;
  logic [DW-1:0] l_wdata, r_wdata;
  logic [DW-1:0] l_rdata, r_rdata;
  logic          l_idle, r_idle;

  int n_chk = 0;
  int n_bad = 0;
  int salt  = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  dp_sema_bank dut (
    .clk_i(clk), .rst_ni(rst_n),
    .l_addr_i(l_addr), .l_sel_ni(l_sel_n), .l_ce_ni(l_ce_n), .l_we_i(l_we),
    .l_wdata_i(l_wdata), .l_rdata_o(l_rdata), .l_idle_o(l_idle),
    .r_addr_i(r_addr), .r_sel_ni(r_sel_n), .r_ce_ni(r_ce_n), .r_we_i(r_we),
    .r_wdata_i(r_wdata), .r_rdata_o(r_rdata), .r_idle_o(r_idle)
  );

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic park();
    l_sel_n = 1; l_ce_n = 1; l_we = 0; l_wdata = '1; l_addr = '0;
    r_sel_n = 1; r_ce_n = 1; r_we = 0; r_wdata = '1; r_addr = '0;
  endtask

  // upper address and data bits vary on every access (R1: they are ignored)
  task automatic drive(input bit side, input logic sel_n, input logic ce_n,
                       input logic we, input int flag, input logic b0);
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    salt++;
    a = {7'(salt * 29), 3'(flag)};
    d = {7'(salt * 11), b0};
    if (side == 0) begin
      l_sel_n = sel_n; l_ce_n = ce_n; l_we = we; l_addr = a; l_wdata = d;
    end else begin
      r_sel_n = sel_n; r_ce_n = ce_n; r_we = we; r_addr = a; r_wdata = d;
    end
  endtask

  task automatic wr(input bit side, input int flag, input logic b0);
    drive(side, 0, 1, 1, flag, b0);
    @(negedge clk); park();
  endtask

  task automatic both_wr(input int flag, input logic b0);
    drive(0, 0, 1, 1, flag, b0);
    drive(1, 0, 1, 1, flag, b0);
    @(negedge clk); park();
  endtask

  task automatic rd(input bit side, input int flag, input bit own, input string tag);
    drive(side, 0, 1, 0, flag, 1'b0);
    #1;
    chk(tag, side ? r_rdata : l_rdata, {7'h7f, !own});
    @(negedge clk); park();
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    park();
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11 reset l_rdata", l_rdata, 8'hff);
    chk("R11 reset r_rdata", r_rdata, 8'hff);
    chk("R10 reset idle", {6'b0, l_idle, r_idle}, 8'h03);
    rst_n = 1;
    @(negedge clk);
    for (int k = 0; k < 8; k++) begin
      rd(0, k, 0, "R11 left free after reset");
      rd(1, k, 0, "R11 right free after reset");
    end

    // R1 R4 R5 R6: per-flag claim, isolation, release
    for (int s = 0; s < 2; s++) begin
      for (int k = 0; k < 8; k++) begin
        wr(s[0], k, 0);
        for (int j = 0; j < 8; j++) rd(s[0], j, j == k, "R1 R4 only claimed flag owned");
        rd(!s[0], k, 0, "R5 other side sees not owned");
        wr(s[0], k, 1);
        rd(s[0], k, 0, "R6 released");
      end
    end

    // R9 R7: tie to left, pending right granted one cycle after release
    for (int k = 0; k < 8; k++) begin
      both_wr(k, 0);
      rd(0, k, 1, "R9 left wins tie");
      rd(1, k, 0, "R9 right pending");
      wr(0, k, 1);
      rd(1, k, 0, "R7 not yet granted at t+1");
      rd(1, k, 1, "R7 granted at t+2");
      rd(0, k, 0, "R7 left no longer owns");
      wr(1, k, 1);
      rd(1, k, 0, "R6 right released");
    end

    // R7 with left pending behind right owner
    wr(1, 6, 0);
    wr(0, 6, 0);
    rd(0, 6, 0, "R7 left pending");
    wr(1, 6, 1);
    rd(0, 6, 0, "R7 left not yet at t+1");
    rd(0, 6, 1, "R7 left granted at t+2");
    wr(0, 6, 1);

    // R8: withdrawal in the cycle after release
    wr(0, 3, 0);
    wr(1, 3, 0);
    wr(0, 3, 1);
    wr(1, 3, 1);
    rd(1, 3, 0, "R8 withdrawn request not granted");
    rd(0, 3, 0, "R8 flag free for left");
    rd(1, 3, 0, "R8 still free");
    wr(1, 3, 0);
    rd(1, 3, 1, "R8 flag claimable after");
    wr(1, 3, 1);

    // R8 variant: withdrawal before the owner releases
    wr(0, 4, 0);
    wr(1, 4, 0);
    wr(1, 4, 1);
    wr(0, 4, 1);
    rd(1, 4, 0, "R8 early withdraw t+1");
    rd(1, 4, 0, "R8 early withdraw t+2");

    // R2: select high, write ignored; no access reads all ones
    drive(0, 1, 1, 1, 2, 0); #1;
    chk("R2 deselected read data", l_rdata, 8'hff);
    @(negedge clk); park();
    rd(0, 2, 0, "R2 deselected write ignored");
    wr(1, 2, 0);
    rd(1, 2, 1, "R2 flag was still free");
    wr(1, 2, 1);

    // R3: chip enable low blocks semaphore access
    drive(0, 0, 0, 1, 5, 0);
    @(negedge clk); park();
    rd(0, 5, 0, "R3 write with ce low ignored");
    wr(1, 5, 0);
    drive(1, 0, 0, 0, 5, 0); #1;
    chk("R3 read with ce low all ones", r_rdata, 8'hff);
    @(negedge clk); park();
    rd(1, 5, 1, "R3 right still owns");
    wr(1, 5, 1);

    // R10: idle per port
    for (int a = 0; a < 16; a++) begin
      l_ce_n = a[0]; l_sel_n = a[1]; r_ce_n = a[2]; r_sel_n = a[3];
      l_we = 0; r_we = 0;
      #1;
      chk("R10 left idle", {7'b0, l_idle}, {7'b0, a[0] & a[1]});
      chk("R10 right idle", {7'b0, r_idle}, {7'b0, a[2] & a[3]});
      @(negedge clk);
    end
    park();

    // R11: reset mid-run
    for (int k = 0; k < 8; k++) wr(k[0], k, 0);
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    for (int k = 0; k < 8; k++) begin
      rd(0, k, 0, "R11 left free after mid reset");
      rd(1, k, 0, "R11 right free after mid reset");
    end
    wr(1, 0, 0);
    rd(1, 0, 1, "R11 claimable after reset");

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule